// File: doc/BRIEF.md
# RC Time-Constant Measurement Sequencer

This block times how long an external resistor-capacitor network takes to charge and to discharge. One free-running 16-bit timer serves as the time base. The block drives the resistor from a single digital pin, `drive_o`. It watches the digital output of an external comparator whose threshold is half the supply and whose input is the capacitor node.

A run is five measurement cycles, and each cycle is a charge phase followed by a discharge phase. Each phase first waits a settling time that scales with the last count of the opposite phase. A compare match on the timer then switches the drive pin. The timer value at the first comparator edge of the expected polarity is captured, and the difference is stored. When ten results are stored, the block presents the charge total and the discharge total and raises a done flag. It then stays quiet until it receives a new start request.

Top module: `rc_tau_seq`

## Requirements
- R1: After reset the outputs are `drive_o`=0, `cmp_en_o`=0, `done_o`=0 and `res_valid_o`=0, and both sums are 0.
- R2: A phase other than the first of a run switches `drive_o` exactly 15*C+1 cycles after the previous result pulse. C is the most recent count of the opposite phase.
- R3: The first charge phase of a run uses C=1000 in place of a discharge count. `drive_o` rises 15002 cycles after the cycle in which `start_i` is driven high.
- R4: Charge phases set `drive_o` high on the match and capture only a rising comparator edge. Discharge phases clear `drive_o` low on the match and capture only a falling edge.
- R5: `cmp_i` passes through a 2-stage synchronizer. A comparator change made D cycles after `drive_o` switches gives a count of D+3. `res_valid_o` pulses 3 cycles after the change.
- R6: Comparator edges that occur before or on the compare-match cycle are ignored. This includes edges of the phase's own polarity.
- R7: Results are indexed 0 to 9. Even indices hold charge counts and odd indices hold discharge counts. `res_idx_o`/`res_cnt_o` show each new result, and `rd_cnt_o` returns entry `rd_idx_i`.
- R8: `cmp_en_o` is high from the start of each cycle through its charge and discharge compare matches. It is low in the cycle that shows that cycle's discharge result.
- R9: `done_o` rises together with the result at index 9. At that point `chg_sum_o` and `dis_sum_o` hold the sums of the even entries and of the odd entries.
- R10: `start_i` has no effect while a run is in progress. After done, the comparator is ignored (no result pulse, sums and drive unchanged) until `start_i`.
- R11: Timer arithmetic wraps modulo 2^16, so counts stay correct when a phase spans the timer rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run of five cycles (honoured when idle or done) |
| cmp_i | input | 1 | Asynchronous comparator output from the capacitor node |
| drive_o | output | 1 | Resistor drive pin |
| cmp_en_o | output | 1 | Comparator power enable |
| done_o | output | 1 | Run complete, sums valid |
| res_valid_o | output | 1 | One-cycle pulse for a new result |
| res_idx_o | output | 4 | Index of the latest result |
| res_cnt_o | output | 16 | Latest count in timer ticks |
| rd_idx_i | input | 4 | Result store read index |
| rd_cnt_o | output | 16 | Result store entry at `rd_idx_i` |
| chg_sum_o | output | 20 | Sum of charge counts of the run |
| dis_sum_o | output | 20 | Sum of discharge counts of the run |

## Verification
The compare match that switches the drive pin and a synchronized comparator edge can fall in the same cycle. Capture must not be armed in that cycle. The bench pulses `cmp_i` so that the leading edge of the pulse reaches the sequencer exactly on the match cycle and its trailing, wrong-polarity edge lands in the first armed cycle. It then makes the real transition later. The run passes only if every count still equals the real delay plus three and every settling gap matches 15*C+1. This confirms that neither stray edge was captured.

// File: rtl/rc_tau_pkg.sv
package rc_tau_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT_CMP,
    ST_WAIT_EDGE,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/rc_tau_timer.sv
module rc_tau_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + TW'(1);
  end
endmodule

// File: rtl/rc_tau_edge.sv
module rc_tau_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/rc_tau_ctrl.sv
module rc_tau_ctrl
  import rc_tau_pkg::*;
#(
  parameter int TW         = 16,
  parameter int N_SLOTS    = 10,
  parameter int SETTLE_MUL = 15,
  parameter int FIRST_DIS  = 1000,
  localparam int IW        = $clog2(N_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] timer_i,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          drive_o,
  output logic          cmp_en_o,
  output logic          done_o,
  output logic          clr_o,
  output logic          cap_o,
  output logic [IW-1:0] cap_idx_o,
  output logic [TW-1:0] cap_cnt_o
);
  seq_st_e       st_q;
  logic [IW-1:0] slot_q;
  logic [TW-1:0] cmp_time_q, prev_chg_q, prev_dis_q;
  logic [TW-1:0] opp_cnt, settle_w;
  logic          dis_phase, hit_edge, last_slot;

  // slot parity selects the phase: even = charge, odd = discharge
  assign dis_phase = slot_q[0];
  assign last_slot = (slot_q == IW'(N_SLOTS - 1));
  assign opp_cnt   = dis_phase ? prev_chg_q : prev_dis_q;
  assign settle_w  = TW'(SETTLE_MUL) * opp_cnt;
  assign hit_edge  = dis_phase ? fall_i : rise_i;

  assign clr_o     = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign cap_o     = (st_q == ST_WAIT_EDGE) && hit_edge;
  assign cap_idx_o = slot_q;
  assign cap_cnt_o = timer_i - cmp_time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      slot_q     <= '0;
      cmp_time_q <= '0;
      prev_chg_q <= '0;
      prev_dis_q <= '0;
      drive_o    <= 1'b0;
      cmp_en_o   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            slot_q     <= '0;
            prev_dis_q <= TW'(FIRST_DIS);
            done_o     <= 1'b0;
            st_q       <= ST_ARM;
          end
        end
        ST_ARM: begin
          cmp_time_q <= timer_i + settle_w;
          if (!dis_phase) cmp_en_o <= 1'b1;
          st_q <= ST_WAIT_CMP;
        end
        ST_WAIT_CMP: begin
          if (timer_i == cmp_time_q) begin
            drive_o <= ~dis_phase;
            st_q    <= ST_WAIT_EDGE;
          end
        end
        ST_WAIT_EDGE: begin
          if (hit_edge) begin
            if (dis_phase) begin
              prev_dis_q <= cap_cnt_o;
              cmp_en_o   <= 1'b0;
            end else begin
              prev_chg_q <= cap_cnt_o;
            end
            if (last_slot) begin
              done_o <= 1'b1;
              st_q   <= ST_DONE;
            end else begin
              slot_q <= slot_q + IW'(1);
              st_q   <= ST_ARM;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DRIVE_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drive_o) |-> $past(st_q == ST_WAIT_CMP)); // R4
  AST_CAPT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (drive_o == ~dis_phase)); // R4
  AST_CAPT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> (st_q == ST_ARM || st_q == ST_DONE)); // R7
  AST_EN_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_EDGE) |-> cmp_en_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |-> (!cmp_en_o && !drive_o && done_o)); // R9
  AST_DONE_NO_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cap_o); // R10
endmodule

// File: rtl/rc_tau_store.sv
module rc_tau_store #(
  parameter int TW      = 16,
  parameter int N_SLOTS = 10,
  localparam int IW     = $clog2(N_SLOTS),
  localparam int SW     = TW + $clog2(N_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [TW-1:0] wr_cnt_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [TW-1:0] rd_cnt_o,
  output logic          res_valid_o,
  output logic [IW-1:0] res_idx_o,
  output logic [TW-1:0] res_cnt_o,
  output logic [SW-1:0] chg_sum_o,
  output logic [SW-1:0] dis_sum_o
);
  logic [TW-1:0] mem_q [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (wr_i && wr_idx_i == IW'(g))         mem_q[g] <= wr_cnt_i;
    end
  end

  always_comb begin
    rd_cnt_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (rd_idx_i == IW'(i)) rd_cnt_o = mem_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_idx_o   <= '0;
      res_cnt_o   <= '0;
      chg_sum_o   <= '0;
      dis_sum_o   <= '0;
    end else begin
      res_valid_o <= wr_i;
      if (clr_i) begin
        chg_sum_o <= '0;
        dis_sum_o <= '0;
      end else if (wr_i) begin
        res_idx_o <= wr_idx_i;
        res_cnt_o <= wr_cnt_i;
        if (wr_idx_i[0]) dis_sum_o <= dis_sum_o + SW'(wr_cnt_i);
        else             chg_sum_o <= chg_sum_o + SW'(wr_cnt_i);
      end
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (wr_idx_i < IW'(N_SLOTS))); // R7
  AST_SUM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (chg_sum_o == '0 && dis_sum_o == '0)); // R9
  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i) |=> ($stable(chg_sum_o) && $stable(dis_sum_o))); // R10
endmodule

// File: rtl/rc_tau_seq.sv
module rc_tau_seq #(
  parameter int TW          = 16,
  parameter int N_SLOTS     = 10,
  parameter int SETTLE_MUL  = 15,
  parameter int FIRST_DIS   = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(N_SLOTS),
  localparam int SW         = TW + $clog2(N_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cmp_i,
  output logic          drive_o,
  output logic          cmp_en_o,
  output logic          done_o,
  output logic          res_valid_o,
  output logic [IW-1:0] res_idx_o,
  output logic [TW-1:0] res_cnt_o,
  input  logic [IW-1:0] rd_idx_i,
  output logic [TW-1:0] rd_cnt_o,
  output logic [SW-1:0] chg_sum_o,
  output logic [SW-1:0] dis_sum_o
);
  logic [TW-1:0] timer;
  logic          rise, fall, clr, cap;
  logic [IW-1:0] cap_idx;
  logic [TW-1:0] cap_cnt;

  rc_tau_timer #(.TW(TW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (timer)
  );

  rc_tau_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cmp_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  rc_tau_ctrl #(
    .TW        (TW),
    .N_SLOTS   (N_SLOTS),
    .SETTLE_MUL(SETTLE_MUL),
    .FIRST_DIS (FIRST_DIS)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .timer_i  (timer),
    .rise_i   (rise),
    .fall_i   (fall),
    .drive_o  (drive_o),
    .cmp_en_o (cmp_en_o),
    .done_o   (done_o),
    .clr_o    (clr),
    .cap_o    (cap),
    .cap_idx_o(cap_idx),
    .cap_cnt_o(cap_cnt)
  );

  rc_tau_store #(.TW(TW), .N_SLOTS(N_SLOTS)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .wr_i       (cap),
    .wr_idx_i   (cap_idx),
    .wr_cnt_i   (cap_cnt),
    .rd_idx_i   (rd_idx_i),
    .rd_cnt_o   (rd_cnt_o),
    .res_valid_o(res_valid_o),
    .res_idx_o  (res_idx_o),
    .res_cnt_o  (res_cnt_o),
    .chg_sum_o  (chg_sum_o),
    .dis_sum_o  (dis_sum_o)
  );
endmodule

// File: tb/test_rc_tau_seq.sv
`timescale 1ns/1ps
module test_rc_tau_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cmp_i = 1'b0;
  logic        drive_o, cmp_en_o, done_o, res_valid_o;
  logic [3:0]  res_idx_o, rd_idx_i;
  logic [15:0] res_cnt_o, rd_cnt_o;
  logic [19:0] chg_sum_o, dis_sum_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt [10];

  always #2.5 clk = ~clk;

  rc_tau_seq i_rc_tau_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .drive_o(drive_o), .cmp_en_o(cmp_en_o), .done_o(done_o),
    .res_valid_o(res_valid_o), .res_idx_o(res_idx_o), .res_cnt_o(res_cnt_o),
    .rd_idx_i(rd_idx_i), .rd_cnt_o(rd_cnt_o),
    .chg_sum_o(chg_sum_o), .dis_sum_o(dis_sum_o)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_set(input int base, input int step, input bit glitch, input int mid);
    int prev_c, prev_d, sum_c, sum_d;
    prev_d = 1000; prev_c = 0; sum_c = 0; sum_d = 0;
    @(negedge clk);
    start_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      bit lvl;
      int opp, gap, d, n, m;
      lvl = ((k % 2) == 0);
      opp = (k % 2) ? prev_c : prev_d;
      gap = (k == 0) ? 15 * opp + 2 : 15 * opp + 1;
      d   = base + step * k;
      n   = 0;
      while (drive_o !== lvl) begin
        @(negedge clk);
        n++;
        if (k == 0 && n == 1) start_i = 1'b0;
        if (k == mid && n == 4) start_i = 1'b1;
        if (k == mid && n == 5) start_i = 1'b0;
        if (glitch && n == gap - 3) cmp_i = lvl;
        if (glitch && n == gap - 2) cmp_i = ~lvl;
      end
      if (k == 0) chk(n == gap, "R3 first settling gap", n, gap);
      else        chk(n == gap, "R2 settling gap", n, gap);
      chk(cmp_en_o == 1'b1, "R8 enable at match", cmp_en_o, 1);
      repeat (d) @(negedge clk);
      cmp_i = lvl;
      m = 0;
      while (res_valid_o !== 1'b1) begin
        @(negedge clk);
        m++;
      end
      chk(m == 3, "R5 capture latency", m, 3);
      if (glitch) chk(res_cnt_o == d + 3, "R6 R4 count after stray edges", res_cnt_o, d + 3);
      else        chk(res_cnt_o == d + 3, "R5 R11 count", res_cnt_o, d + 3);
      chk(res_idx_o == k, "R7 result index", res_idx_o, k);
      exp_cnt[k] = d + 3;
      if (k % 2) begin
        prev_d = d + 3; sum_d += d + 3;
        chk(cmp_en_o == 1'b0, "R8 enable off after discharge", cmp_en_o, 0);
      end else begin
        prev_c = d + 3; sum_c += d + 3;
      end
      chk(done_o == (k == 9), "R9 done flag", done_o, (k == 9));
    end
    chk(chg_sum_o == sum_c, "R9 charge sum", chg_sum_o, sum_c);
    chk(dis_sum_o == sum_d, "R9 discharge sum", dis_sum_o, sum_d);
    for (int i = 0; i < 10; i++) begin
      rd_idx_i = 4'(i);
      #1;
      chk(rd_cnt_o == exp_cnt[i], "R7 store read", rd_cnt_o, exp_cnt[i]);
    end
    // comparator activity after done must be ignored
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cmp_i = (i % 3) == 0;
      if (res_valid_o) chk(1'b0, "R10 result pulse after done", 1, 0);
    end
    cmp_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(res_valid_o == 1'b0 && drive_o == 1'b0 && cmp_en_o == 1'b0,
        "R10 quiet after done", {res_valid_o, drive_o, cmp_en_o}, 0);
    chk(chg_sum_o == sum_c && dis_sum_o == sum_d, "R10 sums held", chg_sum_o, sum_c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rd_idx_i = '0;
    repeat (3) @(negedge clk);
    chk(drive_o == 0 && cmp_en_o == 0 && done_o == 0 && res_valid_o == 0,
        "R1 reset outputs", {drive_o, cmp_en_o, done_o, res_valid_o}, 0);
    chk(chg_sum_o == 0 && dis_sum_o == 0, "R1 reset sums", chg_sum_o + dis_sum_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_set(0, 1, 1'b0, -1);
    run_set(40, 17, 1'b1, 3);   // R6 stray edges, R10 start while busy
    run_set(400, 23, 1'b0, -1); // R11 spans timer rollover
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule